// File: doc/BRIEF.md
# Block Memory Mover with Run-Length and Scatter Modes

This block copies bytes from one place in a 24-bit byte-addressed memory to another without processor help once it has been set up. Software loads a source pointer, a destination pointer, a length, a mode word and a fill byte, then writes the start bit. The engine takes a snapshot of that setup and runs the transfer alone. It raises a sticky done flag at the end, and an interrupt line if software has enabled it.

The engine has four kinds of transfer. A plain copy moves the bytes unchanged. Unpack expands a run-length stream into plain bytes. Pack turns plain bytes into a run-length stream. Scatter stores one byte value at a series of destination addresses, each given as a signed offset from the destination pointer. The memory side is a single-byte request port. The request and everything that goes with it stay steady until the memory accepts the request, so slow memory can insert any number of wait cycles.

Top module: `dma_rle_engine`

## Requirements
- R1: After reset all six registers read as zero, busy and done are clear, `irq` is low and `mem_req` is low.
- R2: Register index 0 holds the source pointer (24 bits) and index 1 the destination pointer (24 bits). Index 2 holds the length (16 bits). Index 3 holds the mode word: bits 1:0 select the kind (0 copy, 1 unpack, 2 pack, 3 scatter) and bit 2 selects zero data in scatter. Index 4 holds the fill byte (8 bits). Index 5 is the control word. Each register reads back what was written, with unused bits read as zero.
- R3: While `mem_req` is high and `mem_ready` is low, the request, address, direction and write data hold steady. An access completes in the cycle `mem_req` and `mem_ready` are both high, and read data is taken in that same cycle.
- R4: Copy (kind 0) moves LEN bytes unchanged from source to destination in ascending address order. Any 24-bit start address is allowed, and the first request goes to the programmed source address.
- R5: Unpack (kind 1) reads a control byte. If bit 7 of the control byte is set, the next byte is written (low 7 bits + 1) times. If bit 7 is clear, (low 7 bits + 1) literal bytes follow and are copied. LEN counts output bytes, and the engine stops after exactly LEN bytes, even if that falls in the middle of a packet.
- R6: Pack (kind 2) consumes LEN source bytes. It writes each maximal run of equal bytes, up to 128 long, as the two-byte packet {0x80 | (run - 1), value}.
- R7: Scatter (kind 3) reads LEN entries from the source. Each entry is a 16-bit little-endian signed offset. For each entry, in order, the engine writes the fill byte (or zero when mode bit 2 is set) to the destination pointer plus the sign-extended offset.
- R8: In the control word, bit 0 (write 1) starts a transfer, bit 1 reads busy, and bit 2 reads done. When a transfer ends, busy clears and done sets. Done stays set until a write to the control word with bit 2 set.
- R9: Bit 3 of the control word is the interrupt enable, loaded by every control write. `irq` is high exactly when done and the enable are both set.
- R10: A start written while busy is ignored. Register writes made while busy do not change the transfer already running.
- R11: A start with LEN zero ends at once with done set and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 24 | Register write data |
| cfg_rdata | output | 24 | Register read data for `cfg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while the request is accepted |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check four things on every cycle. The request stays steady through wait cycles. No request appears while the engine is idle. Done stays set until it is cleared, and it only rises at the end of a busy period. An empty transfer never reaches the memory port. Only the bench's scenarios can show that the contents are right: the copied bytes, the expanded and packed run-length streams (including packets cut short by the length and runs longer than 128), and scatter stores that overwrite one another in list order. The scenarios also show that a second start during a transfer changes nothing and that the interrupt follows the enable.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int ADDR_W  = 24;
    localparam int LEN_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int OFS_W   = 16;
    localparam int CNT_W   = 7;
    localparam int REG_W   = ADDR_W;
    localparam int RIDX_W  = 3;

    localparam logic [RIDX_W-1:0] RI_SRC  = 3'd0;
    localparam logic [RIDX_W-1:0] RI_DST  = 3'd1;
    localparam logic [RIDX_W-1:0] RI_LEN  = 3'd2;
    localparam logic [RIDX_W-1:0] RI_MODE = 3'd3;
    localparam logic [RIDX_W-1:0] RI_FILL = 3'd4;
    localparam logic [RIDX_W-1:0] RI_CTRL = 3'd5;

    localparam int CB_START = 0;
    localparam int CB_BUSY  = 1;
    localparam int CB_DONE  = 2;
    localparam int CB_IEN   = 3;

    typedef enum logic [1:0] {
        K_COPY    = 2'd0,
        K_UNPACK  = 2'd1,
        K_PACK    = 2'd2,
        K_SCATTER = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
        xfer_kind_e        kind;
        logic              zero_fill;
        logic [BYTE_W-1:0] fill;
    } xfer_cfg_t;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } mem_cmd_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CP_RD,  S_CP_WR,
        S_UP_CTL, S_UP_VAL, S_UP_REP, S_UP_LRD, S_UP_LWR,
        S_PK_FIRST, S_PK_NEXT, S_PK_CTL, S_PK_VAL,
        S_SC_LO,  S_SC_HI,  S_SC_WR,
        S_DONE
    } eng_state_e;

    function automatic logic pkt_is_run(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1];
    endfunction

    function automatic logic [CNT_W-1:0] pkt_count(input logic [BYTE_W-1:0] b);
        return b[CNT_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] run_header(input logic [CNT_W-1:0] n_minus_1);
        return {1'b1, n_minus_1};
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] idx,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              busy,
    input  logic              done_set,
    output xfer_cfg_t         cfg,
    output logic              go,
    output logic              done,
    output logic              irq
);

    logic ien;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            ien  <= 1'b0;
            done <= 1'b0;
        end else begin
            if (wr_en) begin
                case (idx)
                    RI_SRC:  cfg.src  <= wdata[ADDR_W-1:0];
                    RI_DST:  cfg.dst  <= wdata[ADDR_W-1:0];
                    RI_LEN:  cfg.len  <= wdata[LEN_W-1:0];
                    RI_MODE: begin
                        cfg.kind      <= xfer_kind_e'(wdata[1:0]);
                        cfg.zero_fill <= wdata[2];
                    end
                    RI_FILL: cfg.fill <= wdata[BYTE_W-1:0];
                    RI_CTRL: begin
                        ien <= wdata[CB_IEN];
                        if (wdata[CB_DONE]) done <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (done_set) done <= 1'b1;
        end
    end

    assign go  = wr_en && (idx == RI_CTRL) && wdata[CB_START] && !busy;
    assign irq = done && ien;

    always_comb begin
        rdata = '0;
        case (idx)
            RI_SRC:  rdata[ADDR_W-1:0] = cfg.src;
            RI_DST:  rdata[ADDR_W-1:0] = cfg.dst;
            RI_LEN:  rdata[LEN_W-1:0]  = cfg.len;
            RI_MODE: rdata[2:0]        = {cfg.zero_fill, cfg.kind};
            RI_FILL: rdata[BYTE_W-1:0] = cfg.fill;
            RI_CTRL: begin
                rdata[CB_BUSY] = busy;
                rdata[CB_DONE] = done;
                rdata[CB_IEN]  = ien;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_offset_calc.sv
module dma_offset_calc #(
    parameter int AW = 24,
    parameter int OW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] ofs,
    output logic [AW-1:0] target
);

    localparam int EXT_W = AW - OW;

    logic [AW-1:0] ofs_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            assign ofs_ext = {{EXT_W{ofs[OW-1]}}, ofs};
        end else begin : g_trim
            assign ofs_ext = ofs[AW-1:0];
        end
    endgenerate

    assign target = base + ofs_ext;

endmodule

// File: rtl/dma_core.sv
module dma_core
    import dma_pkg::*;
#(
    parameter int RUN_MAX = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  xfer_cfg_t         cfg,
    input  logic              mem_ready,
    input  logic [BYTE_W-1:0] mem_rdata,
    output mem_cmd_t          cmd,
    output logic              busy,
    output logic              done_set
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_MAX - 1);

    eng_state_e        state;
    logic [ADDR_W-1:0] sa, da, tgt, tgt_next;
    logic [LEN_W-1:0]  rem;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] hold, nxt, lo;
    logic              zero_q, pend, src_end;
    logic [BYTE_W-1:0] fill_q;
    logic              last;

    assign last = (rem == LEN_W'(1));

    dma_offset_calc #(.AW(ADDR_W), .OW(OFS_W)) u_ofs (
        .base   (da),
        .ofs    ({mem_rdata, lo}),
        .target (tgt_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            sa      <= '0;
            da      <= '0;
            tgt     <= '0;
            rem     <= '0;
            cnt     <= '0;
            hold    <= '0;
            nxt     <= '0;
            lo      <= '0;
            zero_q  <= 1'b0;
            fill_q  <= '0;
            pend    <= 1'b0;
            src_end <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (go) begin
                    sa      <= cfg.src;
                    da      <= cfg.dst;
                    rem     <= cfg.len;
                    zero_q  <= cfg.zero_fill;
                    fill_q  <= cfg.fill;
                    pend    <= 1'b0;
                    src_end <= 1'b0;
                    cnt     <= '0;
                    if (cfg.len == '0) state <= S_DONE;
                    else begin
                        case (cfg.kind)
                            K_COPY:   state <= S_CP_RD;
                            K_UNPACK: state <= S_UP_CTL;
                            K_PACK:   state <= S_PK_FIRST;
                            default:  state <= S_SC_LO;
                        endcase
                    end
                end
                S_CP_RD: if (mem_ready) begin
                    hold  <= mem_rdata;
                    sa    <= sa + 1'b1;
                    state <= S_CP_WR;
                end
                S_CP_WR: if (mem_ready) begin
                    da    <= da + 1'b1;
                    rem   <= rem - 1'b1;
                    state <= last ? S_DONE : S_CP_RD;
                end
                S_UP_CTL: if (mem_ready) begin
                    sa    <= sa + 1'b1;
                    cnt   <= pkt_count(mem_rdata);
                    state <= pkt_is_run(mem_rdata) ? S_UP_VAL : S_UP_LRD;
                end
                S_UP_VAL: if (mem_ready) begin
                    hold  <= mem_rdata;
                    sa    <= sa + 1'b1;
                    state <= S_UP_REP;
                end
                S_UP_REP: if (mem_ready) begin
                    da  <= da + 1'b1;
                    rem <= rem - 1'b1;
                    if (last)             state <= S_DONE;
                    else if (cnt == '0)   state <= S_UP_CTL;
                    else                  cnt   <= cnt - 1'b1;
                end
                S_UP_LRD: if (mem_ready) begin
                    hold  <= mem_rdata;
                    sa    <= sa + 1'b1;
                    state <= S_UP_LWR;
                end
                S_UP_LWR: if (mem_ready) begin
                    da  <= da + 1'b1;
                    rem <= rem - 1'b1;
                    if (last)             state <= S_DONE;
                    else if (cnt == '0)   state <= S_UP_CTL;
                    else begin
                        cnt   <= cnt - 1'b1;
                        state <= S_UP_LRD;
                    end
                end
                S_PK_FIRST: if (mem_ready) begin
                    hold <= mem_rdata;
                    cnt  <= '0;
                    sa   <= sa + 1'b1;
                    rem  <= rem - 1'b1;
                    if (last) begin
                        src_end <= 1'b1;
                        state   <= S_PK_CTL;
                    end else begin
                        state   <= S_PK_NEXT;
                    end
                end
                S_PK_NEXT: if (mem_ready) begin
                    sa  <= sa + 1'b1;
                    rem <= rem - 1'b1;
                    if (last) src_end <= 1'b1;
                    if (mem_rdata == hold && cnt != CNT_LAST) begin
                        cnt <= cnt + 1'b1;
                        if (last) state <= S_PK_CTL;
                    end else begin
                        nxt   <= mem_rdata;
                        pend  <= 1'b1;
                        state <= S_PK_CTL;
                    end
                end
                S_PK_CTL: if (mem_ready) begin
                    da    <= da + 1'b1;
                    state <= S_PK_VAL;
                end
                S_PK_VAL: if (mem_ready) begin
                    da <= da + 1'b1;
                    if (pend) begin
                        hold  <= nxt;
                        cnt   <= '0;
                        pend  <= 1'b0;
                        state <= src_end ? S_PK_CTL : S_PK_NEXT;
                    end else begin
                        state <= S_DONE;
                    end
                end
                S_SC_LO: if (mem_ready) begin
                    lo    <= mem_rdata;
                    sa    <= sa + 1'b1;
                    state <= S_SC_HI;
                end
                S_SC_HI: if (mem_ready) begin
                    tgt   <= tgt_next;
                    sa    <= sa + 1'b1;
                    state <= S_SC_WR;
                end
                S_SC_WR: if (mem_ready) begin
                    rem   <= rem - 1'b1;
                    state <= last ? S_DONE : S_SC_LO;
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd = '0;
        case (state)
            S_CP_RD, S_UP_CTL, S_UP_VAL, S_UP_LRD,
            S_PK_FIRST, S_PK_NEXT, S_SC_LO, S_SC_HI: begin
                cmd.req  = 1'b1;
                cmd.addr = sa;
            end
            S_CP_WR, S_UP_REP, S_UP_LWR, S_PK_VAL: begin
                cmd.req   = 1'b1;
                cmd.we    = 1'b1;
                cmd.addr  = da;
                cmd.wdata = hold;
            end
            S_PK_CTL: begin
                cmd.req   = 1'b1;
                cmd.we    = 1'b1;
                cmd.addr  = da;
                cmd.wdata = run_header(cnt);
            end
            S_SC_WR: begin
                cmd.req   = 1'b1;
                cmd.we    = 1'b1;
                cmd.addr  = tgt;
                cmd.wdata = zero_q ? '0 : fill_q;
            end
            default: cmd = '0;
        endcase
    end

    assign busy     = (state != S_IDLE);
    assign done_set = (state == S_DONE);

endmodule

// File: rtl/dma_rle_engine.sv
module dma_rle_engine
    import dma_pkg::*;
#(
    parameter int RUN_MAX = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [RIDX_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              irq
);

    xfer_cfg_t cfg_q;
    mem_cmd_t  cmd;
    logic      busy_w, done_w, go_w, done_set_w;

    dma_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .idx      (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .busy     (busy_w),
        .done_set (done_set_w),
        .cfg      (cfg_q),
        .go       (go_w),
        .done     (done_w),
        .irq      (irq)
    );

    dma_core #(.RUN_MAX(RUN_MAX)) u_core (
        .clk       (clk),
        .rst       (rst),
        .go        (go_w),
        .cfg       (cfg_q),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .cmd       (cmd),
        .busy      (busy_w),
        .done_set  (done_set_w)
    );

    assign mem_req   = cmd.req;
    assign mem_we    = cmd.we;
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;

endmodule

// File: rtl/dma_rle_engine_chk.sv
module dma_rle_engine_chk
    import dma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BYTE_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              busy,
    input logic              done,
    input logic              go,
    input logic              len_zero,
    input logic              clr_done
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && !clr_done) |=> done); // R8

    AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy)); // R8

    AST_EMPTY_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (go && len_zero) |=> !mem_req); // R11

endmodule

bind dma_rle_engine dma_rle_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .busy      (busy_w),
    .done      (done_w),
    .go        (go_w),
    .len_zero  (cfg_q.len == '0),
    .clr_done  (cfg_we && cfg_addr == 3'd5 && cfg_wdata[2])
);

// File: tb/sim_dma_rle_engine.sv
`timescale 1ns/1ps
module sim_dma_rle_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] cfg_rdata;
    logic        mem_req, mem_we, irq;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;

    logic [7:0] mem    [0:65535];
    logic [7:0] shadow [0:65535];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int req_cycles = 0;
    int ready_mode = 1;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_rle_engine u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq)
    );

    assign mem_rdata = mem[mem_addr[15:0]];

    always @(posedge clk) begin
        if (mem_req && mem_ready && mem_we) mem[mem_addr[15:0]] <= mem_wdata;
        if (mem_req) req_cycles <= req_cycles + 1;
    end

    always @(negedge clk) begin
        if (ready_mode == 0)      mem_ready <= 1'b0;
        else if (ready_mode == 1) mem_ready <= 1'b1;
        else                      mem_ready <= (($urandom % 4) != 0);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors = errors + 1;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input int idx, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = idx[2:0]; cfg_wdata = val[23:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input int idx, output int val);
        cfg_addr = idx[2:0];
        #1;
        val = int'(cfg_rdata);
    endtask

    task automatic wait_idle();
        int v;
        int n = 0;
        reg_rd(5, v);
        while (v[1] && n < 20000) begin
            @(negedge clk);
            reg_rd(5, v);
            n++;
        end
        if (n >= 20000) chk(0, "R8 busy never cleared", v, 0);
    endtask

    task automatic init_mem();
        for (int i = 0; i < 65536; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            mem[i] = b;
            shadow[i] = b;
        end
    endtask

    task automatic put(input int a, input int b);
        mem[a & 16'hFFFF] = b[7:0];
        shadow[a & 16'hFFFF] = b[7:0];
    endtask

    task automatic compare_mem(input string req);
        int bad = 0;
        int first = 0;
        for (int i = 0; i < 65536; i++) begin
            if (mem[i] !== shadow[i]) begin
                if (bad == 0) first = i;
                bad++;
            end
        end
        chk(bad == 0, req, int'(mem[first]), int'(shadow[first]));
        if (bad != 0) $display("  first mismatch at %0h, %0d bytes differ", first, bad);
    endtask

    task automatic launch(input int src, input int dst, input int len, input int mode, input int fill);
        reg_wr(0, src); reg_wr(1, dst); reg_wr(2, len);
        reg_wr(3, mode); reg_wr(4, fill);
        reg_wr(5, 24'h9);
    endtask

    task automatic finish_and_clear();
        wait_idle();
        reg_wr(5, 24'h4);
    endtask

    task automatic do_copy(input int src, input int dst, input int len);
        init_mem();
        for (int i = 0; i < len; i++) shadow[(dst + i) & 16'hFFFF] = mem[(src + i) & 16'hFFFF];
        launch(src, dst, len, 0, 0);
        finish_and_clear();
        compare_mem("R4 copy");
    endtask

    task automatic do_unpack(input int len, input bit big);
        int src = 24'h1000, dst = 24'h8000;
        int outn = 0, p = 24'h1000;
        init_mem();
        while (outn < len) begin
            bit rep;
            int n, ctl;
            rep = $urandom % 2;
            ctl = big ? 127 : ($urandom % 16);
            n = ctl + 1;
            if (rep) begin
                int v = $urandom % 256;
                put(p, ctl | 8'h80); put(p + 1, v); p += 2;
                for (int k = 0; k < n; k++) begin
                    if (outn < len) shadow[dst + outn] = v[7:0];
                    outn++;
                end
            end else begin
                put(p, ctl); p++;
                for (int k = 0; k < n; k++) begin
                    int b = $urandom % 256;
                    put(p, b); p++;
                    if (outn < len) shadow[dst + outn] = b[7:0];
                    outn++;
                end
            end
        end
        launch(src, dst, len, 1, 0);
        finish_and_clear();
        compare_mem("R5 unpack");
    endtask

    task automatic do_pack(input int len, input bit one_val);
        int src = 24'h1000, dst = 24'h8000;
        int i = 0, o = 24'h8000;
        init_mem();
        while (i < len) begin
            int v = one_val ? 8'h3C : ($urandom % 3);
            int r = $urandom % 6 + 1;
            if (one_val) r = len;
            for (int k = 0; k < r && i < len; k++) begin put(src + i, v); i++; end
        end
        i = 0;
        while (i < len) begin
            logic [7:0] v;
            int n = 1;
            v = mem[src + i];
            while (i + n < len && mem[src + i + n] == v && n < 128) n++;
            shadow[o] = 8'h80 | 8'(n - 1);
            shadow[o + 1] = v;
            o += 2;
            i += n;
        end
        launch(src, dst, len, 2, 0);
        finish_and_clear();
        compare_mem("R6 pack");
    endtask

    task automatic do_scatter(input int cnt, input bit zero, input int fill);
        int src = 24'h1000, dst = 24'h8400;
        init_mem();
        for (int e = 0; e < cnt; e++) begin
            int off = int'($urandom % 1024) - 512;
            if (e == cnt - 1) off = -1;
            put(src + 2 * e, off & 255);
            put(src + 2 * e + 1, (off >> 8) & 255);
            shadow[(dst + off) & 16'hFFFF] = zero ? 8'h00 : fill[7:0];
        end
        launch(src, dst, cnt, zero ? 7 : 3, fill);
        finish_and_clear();
        compare_mem("R7 scatter");
    endtask

    initial begin
        int v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int r = 0; r < 6; r++) begin
            reg_rd(r, v);
            chk(v == 0, "R1 register reset value", v, 0);
        end
        chk(mem_req == 0, "R1 mem_req after reset", int'(mem_req), 0);
        chk(irq == 0, "R1 irq after reset", int'(irq), 0);

        reg_wr(0, 24'hABCDEF); reg_rd(0, v); chk(v == 24'hABCDEF, "R2 source readback", v, 24'hABCDEF);
        reg_wr(1, 24'h123456); reg_rd(1, v); chk(v == 24'h123456, "R2 dest readback", v, 24'h123456);
        reg_wr(2, 24'hFFBEEF); reg_rd(2, v); chk(v == 24'h00BEEF, "R2 length readback", v, 24'hBEEF);
        reg_wr(3, 24'hFFFFFF); reg_rd(3, v); chk(v == 7, "R2 mode readback", v, 7);
        reg_wr(4, 24'h12345A); reg_rd(4, v); chk(v == 24'h5A, "R2 fill readback", v, 24'h5A);

        // R3 and R4: wait cycles hold the first read of a high-address copy
        init_mem();
        for (int i = 0; i < 40; i++) shadow[16'h8000 + i] = mem[16'h3400 + i];
        ready_mode = 0;
        launch(24'h123400, 24'hFE8000, 40, 0, 0);
        repeat (10) @(negedge clk);
        chk(mem_req == 1, "R3 request held during wait", int'(mem_req), 1);
        chk(mem_addr == 24'h123400, "R4 first address is programmed source", int'(mem_addr), 24'h123400);
        chk(mem_we == 0, "R3 first access is a read", int'(mem_we), 0);
        ready_mode = 2;
        wait_idle();
        compare_mem("R3 R4 copy across wait cycles");

        reg_rd(5, v);
        chk(v[2] == 1, "R8 done set after transfer", v, v | 4);
        chk(irq == 1, "R9 irq with enable and done", int'(irq), 1);
        repeat (5) @(negedge clk);
        reg_rd(5, v);
        chk(v[2] == 1 && v[1] == 0, "R8 done sticky, busy clear", v, 24'hC);
        reg_wr(5, 0);
        chk(irq == 0, "R9 irq low with enable clear", int'(irq), 0);
        reg_rd(5, v);
        chk(v[2] == 1, "R8 done kept by write without clear bit", v, 4);
        reg_wr(5, 24'h4);
        reg_rd(5, v);
        chk(v[2] == 0, "R8 done cleared by write 1", v, 0);

        for (int t = 0; t < 4; t++)
            do_copy(24'h1000 + ($urandom % 4096), 24'h8000 + ($urandom % 256), 1 + $urandom % 300);

        do_unpack(200, 0);
        do_unpack(37, 0);
        do_unpack(1, 0);
        do_unpack(300, 1);

        do_pack(250, 0);
        do_pack(1, 0);
        do_pack(300, 1);
        do_pack(129, 1);

        do_scatter(40, 0, 8'hA5);
        do_scatter(60, 1, 8'h77);
        do_scatter(1, 0, 8'h11);

        // R10: start and config writes while busy change nothing
        init_mem();
        for (int i = 0; i < 200; i++) shadow[16'h8000 + i] = mem[16'h1000 + i];
        launch(24'h1000, 24'h8000, 200, 0, 0);
        reg_wr(2, 3);
        reg_wr(1, 24'h8800);
        reg_wr(5, 24'h9);
        reg_rd(5, v);
        chk(v[1] == 1, "R10 still busy after second start", v, 2);
        finish_and_clear();
        compare_mem("R10 start while busy ignored");

        // R11: empty transfer
        reg_wr(2, 0);
        init_mem();
        req_cycles = 0;
        reg_wr(5, 24'h9);
        @(negedge clk);
        wait_idle();
        reg_rd(5, v);
        chk(v[2] == 1, "R11 empty transfer sets done", v, 4);
        chk(req_cycles == 0, "R11 empty transfer makes no request", req_cycles, 0);
        compare_mem("R11 memory untouched");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule